// File: doc/BRIEF.md
# Interrupt Enable and Aggregation Unit

This unit gathers the event indications of a host controller into one interrupt request line. One-cycle event pulses latch into a status register. A 32-bit enable register decides which latched events count. A master enable bit at position 31 gates the whole result. The request output goes high only when at least one latched event has its enable bit set and the master bit is also set.

Software reaches the unit through an 8-bit command code with a 32-bit write word. The enable register is never written as a whole. One command sets the bits where the word holds ones, and a second command clears the bits where the word holds ones. Zeros in the word leave bits alone for both commands. The status register is cleared by writing ones to it. An event that arrives in the same cycle as a clear wins over the clear.

Top module: `irq_enable_agg`

## Requirements
- R1: After a synchronous active-low reset, the enable register, the status register, `irq_req`, `rd_data` and `rd_valid` are all 0.
- R2: Command 0x84 sets every implemented enable bit whose write bit is 1. Write bits that are 0 leave their enable bits unchanged.
- R3: Command 0x04 returns the current enable register on `rd_data`, with `rd_valid` high, in the cycle after the command is sampled. Command 0x03 does the same for the status register. Any other command, or no command, leaves `rd_valid` low.
- R4: The implemented enable bits are bit 31 (master enable), bit 0 (scheduling overrun), bit 2 (start of frame), bit 3 (resume detected), bit 4 (unrecoverable error), bit 5 (frame number overflow) and bit 6 (root hub status change). Bit 1 and bits 7 to 30 always read 0 and ignore writes.
- R5: Command 0x85 clears every implemented enable bit whose write bit is 1, master enable included. Bits written as 0 are unchanged.
- R6: A 1 on `evt_pulse[i]` sets status bit i for i in {0,2,3,4,5,6}. Event inputs on any other position are ignored, so those status bits read 0.
- R7: Command 0x83 clears every status bit whose write bit is 1. If an event pulse and a clear hit the same bit in the same cycle, the bit ends up set.
- R8: `irq_req` is registered. It is 1 in the cycle after the status register, enable register and master bit together satisfy (status & enable) != 0 with enable bit 31 = 1. It is 0 in the cycle after that condition stops holding.
- R9: Each of the six events raises `irq_req` only while its own enable bit is set. An event whose enable bit is clear does not raise the request, even when the master bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_code | input | 8 | Command code |
| cmd_wdata | input | 32 | Write word for set, clear and write-one-to-clear commands |
| evt_pulse | input | 32 | One-cycle event pulses, by status bit position |
| rd_data | output | 32 | Read result, registered |
| rd_valid | output | 1 | rd_data holds the result of a read command |
| irq_req | output | 1 | Active-high level interrupt request |

## Verification
A command or event that the rising edge samples in cycle N updates the enable or status register at that edge. The update shows on a read result one cycle after the read command, and on `irq_req` one edge later still (cycle N+1). The bench drives inputs on the falling edge. It checks register effects through a read issued afterwards, sampled at the falling edge after the read is captured. It checks `irq_req` only after a further full cycle, so it samples both when the request should have risen and when it should have fallen. The bench keeps its own model of both registers, built only from the requirements.

// File: rtl/irqagg_pkg.sv
// Package: shared constants and types for the interrupt enable and
// aggregation unit. Assumes a 32-bit register word and 8-bit command codes.
package irqagg_pkg;
    localparam int DATA_W  = 32;
    localparam int CODE_W  = 8;
    localparam int MIE_POS = 31;

    // Event positions that exist: 0, 2, 3, 4, 5, 6
    localparam logic [DATA_W-1:0] EVENT_BITS  = 32'h0000_007D;
    localparam logic [DATA_W-1:0] ENABLE_BITS = EVENT_BITS | (32'h1 << MIE_POS);

    localparam logic [CODE_W-1:0] OP_EN_READ  = 8'h04;
    localparam logic [CODE_W-1:0] OP_EN_SET   = 8'h84;
    localparam logic [CODE_W-1:0] OP_EN_CLEAR = 8'h85;
    localparam logic [CODE_W-1:0] OP_ST_READ  = 8'h03;
    localparam logic [CODE_W-1:0] OP_ST_W1C   = 8'h83;

    typedef struct packed {
        logic en_read;
        logic en_set;
        logic en_clear;
        logic st_read;
        logic st_w1c;
    } op_sel_t;
endpackage

// File: rtl/irqagg_cmd_decode.sv
// Module: turns a command code into one-hot operation strobes.
// Assumes the code is only meaningful while cmd_valid is high; unknown
// codes produce no strobe.
module irqagg_cmd_decode
    import irqagg_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input  logic          cmd_valid,
    input  logic [CW-1:0] cmd_code,
    output op_sel_t       sel
);
    // Purpose: compare the code against each supported operation.
    always_comb begin
        sel          = '0;
        sel.en_read  = cmd_valid && (cmd_code == OP_EN_READ);
        sel.en_set   = cmd_valid && (cmd_code == OP_EN_SET);
        sel.en_clear = cmd_valid && (cmd_code == OP_EN_CLEAR);
        sel.st_read  = cmd_valid && (cmd_code == OP_ST_READ);
        sel.st_w1c   = cmd_valid && (cmd_code == OP_ST_W1C);
    end
endmodule

// File: rtl/irqagg_enable_reg.sv
// Module: enable register with separate set-by-ones and clear-by-ones paths.
// Assumes set and clear never strobe in the same cycle, since the decoder
// makes them one-hot. Bits outside MASK stay 0.
module irqagg_enable_reg #(
    parameter int          W    = 32,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         do_set,
    input  logic         do_clear,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en_q
);
    logic [W-1:0] set_vec;
    logic [W-1:0] clr_vec;
    logic [W-1:0] en_d;

    // Purpose: form the masked set and clear vectors and the next value.
    always_comb begin
        set_vec = do_set   ? (wdata & MASK) : '0;
        clr_vec = do_clear ? (wdata & MASK) : '0;
        en_d    = (en_q | set_vec) & ~clr_vec & MASK;
    end

    // Purpose: hold the enable bits; synchronous reset to all zero.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end
endmodule

// File: rtl/irqagg_status_reg.sv
// Module: per-bit status latches set by event pulses and cleared by
// write-one-to-clear. A set wins over a clear in the same cycle.
// Assumes pulses are synchronous to clk. Only positions in MASK exist.
module irqagg_status_reg #(
    parameter int           W    = 32,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         do_w1c,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] evt,
    output logic [W-1:0] st_q
);
    logic [W-1:0] st_d;

    // Purpose: apply the clear first, then the event, so that the event wins.
    always_comb begin
        st_d = st_q;
        if (do_w1c) st_d = st_d & ~wdata;
        st_d = (st_d | evt) & MASK;
    end

    // Purpose: one status flop per position; positions outside MASK are tied off.
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_live
            always_ff @(posedge clk) begin
                if (!rst_n) st_q[i] <= 1'b0;
                else        st_q[i] <= st_d[i];
            end
        end else begin : g_tied
            assign st_q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/irqagg_irq_gen.sv
// Module: registered interrupt request from status, per-event enables and
// the master enable. Assumes the status has no bit at the master position.
module irqagg_irq_gen #(
    parameter int           W       = 32,
    parameter int           MIE_BIT = 31,
    parameter logic [W-1:0] EV_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] st,
    input  logic [W-1:0] en,
    output logic         irq_q
);
    logic any_hit;
    logic irq_d;

    // Purpose: detect an enabled pending event, gated by the master bit.
    always_comb begin
        any_hit = |(st & en & EV_MASK);
        irq_d   = any_hit && en[MIE_BIT];
    end

    // Purpose: register the request so it is a clean level.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end
endmodule

// File: rtl/irq_enable_agg.sv
// Module: top of the interrupt enable and aggregation unit. Decodes the
// commands, holds the enable and status registers, returns registered read
// data and drives the interrupt request. Assumes at most one command per cycle.
module irq_enable_agg
    import irqagg_pkg::*;
#(
    parameter int           W       = DATA_W,
    parameter int           CW      = CODE_W,
    parameter int           MIE_BIT = MIE_POS,
    parameter logic [W-1:0] EV_MASK = EVENT_BITS,
    parameter logic [W-1:0] EN_MASK = ENABLE_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [CW-1:0] cmd_code,
    input  logic [W-1:0]  cmd_wdata,
    input  logic [W-1:0]  evt_pulse,
    output logic [W-1:0]  rd_data,
    output logic          rd_valid,
    output logic          irq_req
);
    op_sel_t      sel;
    logic [W-1:0] en_q;
    logic [W-1:0] st_q;
    logic [W-1:0] rd_d;

    irqagg_cmd_decode #(.CW(CW)) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .sel       (sel)
    );

    irqagg_enable_reg #(.W(W), .MASK(EN_MASK)) u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .do_set   (sel.en_set),
        .do_clear (sel.en_clear),
        .wdata    (cmd_wdata),
        .en_q     (en_q)
    );

    irqagg_status_reg #(.W(W), .MASK(EV_MASK)) u_st (
        .clk    (clk),
        .rst_n  (rst_n),
        .do_w1c (sel.st_w1c),
        .wdata  (cmd_wdata),
        .evt    (evt_pulse),
        .st_q   (st_q)
    );

    irqagg_irq_gen #(.W(W), .MIE_BIT(MIE_BIT), .EV_MASK(EV_MASK)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .st    (st_q),
        .en    (en_q),
        .irq_q (irq_req)
    );

    // Purpose: select the register that a read command names.
    always_comb begin
        if (sel.en_read)      rd_d = en_q;
        else if (sel.st_read) rd_d = st_q;
        else                  rd_d = '0;
    end

    // Purpose: register the read result and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_data  <= rd_d;
            rd_valid <= sel.en_read | sel.st_read;
        end
    end
endmodule

// File: rtl/irq_enable_agg_chk.sv
// Module: property checker for irq_enable_agg, attached by bind.
// Assumes the default parameter set of the top.
module irq_enable_agg_chk
    import irqagg_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic [7:0]  cmd_code,
    input logic [31:0] cmd_wdata,
    input logic [31:0] evt_pulse,
    input logic [31:0] en_q,
    input logic [31:0] st_q,
    input logic        irq_req
);
    // R2
    set_keeps_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == OP_EN_SET) |=> ((en_q & $past(en_q)) == $past(en_q)));

    // R4
    reserved_en_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q & ~ENABLE_BITS) == 32'h0);

    // R5
    clear_drops_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == OP_EN_CLEAR) |=> ((en_q & $past(cmd_wdata)) == 32'h0));

    // R6
    reserved_st_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q & ~EVENT_BITS) == 32'h0);

    // R7
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_pulse & EVENT_BITS) != 32'h0) |=> ((st_q & $past(evt_pulse & EVENT_BITS)) == $past(evt_pulse & EVENT_BITS)));

    // R8
    irq_needs_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q[MIE_POS] |=> !irq_req);

    // R9
    irq_needs_enabled_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q & en_q) == 32'h0) |=> !irq_req);
endmodule

bind irq_enable_agg irq_enable_agg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_wdata (cmd_wdata),
    .evt_pulse (evt_pulse),
    .en_q      (en_q),
    .st_q      (st_q),
    .irq_req   (irq_req)
);

// File: tb/irq_enable_agg_bench.sv
// Bench: directed scenarios for irq_enable_agg, one task per scenario.
// Inputs change on the falling edge; outputs are sampled on the falling edge.
module irq_enable_agg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_code = 8'h00;
    logic [31:0] cmd_wdata = 32'h0;
    logic [31:0] evt_pulse = 32'h0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        irq_req;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_en = 32'h0;
    logic [31:0] m_st = 32'h0;
    localparam logic [31:0] EVM = 32'h0000_007D;
    localparam logic [31:0] ENM = 32'h8000_007D;

    always #10 clk = ~clk;

    irq_enable_agg u_irq_enable_agg (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_wdata(cmd_wdata), .evt_pulse(evt_pulse), .rd_data(rd_data),
        .rd_valid(rd_valid), .irq_req(irq_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One command, sampled at the next rising edge; returns at the falling edge after it.
    task automatic cmd(input logic [7:0] code, input logic [31:0] data);
        cmd_valid = 1'b1; cmd_code = code; cmd_wdata = data;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_code = 8'h00; cmd_wdata = 32'h0;
    endtask

    task automatic rd(input logic [7:0] code, output logic [31:0] v, input string req);
        cmd_valid = 1'b1; cmd_code = code;
        @(negedge clk);
        chk(req, {31'h0, rd_valid}, 32'h1);
        v = rd_data;
        cmd_valid = 1'b0; cmd_code = 8'h00;
    endtask

    task automatic pulse(input logic [31:0] e);
        evt_pulse = e;
        @(negedge clk);
        evt_pulse = 32'h0;
    endtask

    // Model-side helpers
    task automatic en_set(input logic [31:0] d);  cmd(8'h84, d); m_en = (m_en | d) & ENM; endtask
    task automatic en_clr(input logic [31:0] d);  cmd(8'h85, d); m_en = m_en & ~(d & ENM); endtask
    task automatic st_clr(input logic [31:0] d);  cmd(8'h83, d); m_st = m_st & ~d; endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1 irq", {31'h0, irq_req}, 32'h0);
        chk("R1 rd_valid", {31'h0, rd_valid}, 32'h0);
        chk("R1 rd_data", rd_data, 32'h0);
        rd(8'h04, v, "R3 valid"); chk("R1 enable", v, 32'h0);
        rd(8'h03, v, "R3 valid"); chk("R1 status", v, 32'h0);
    endtask

    task automatic t_set_only;
        logic [31:0] v;
        en_set(32'h0000_0005);
        rd(8'h04, v, "R3 valid"); chk("R2 set ones", v, m_en);
        en_set(32'h0000_0000);
        rd(8'h04, v, "R3 valid"); chk("R2 zeros ignored", v, 32'h0000_0005);
        en_set(32'h0000_0010);
        rd(8'h04, v, "R3 valid"); chk("R2 accumulate", v, 32'h0000_0015);
        @(negedge clk);
        chk("R3 no read no valid", {31'h0, rd_valid}, 32'h0);
    endtask

    task automatic t_reserved;
        logic [31:0] v;
        en_set(32'hFFFF_FFFF);
        rd(8'h04, v, "R3 valid"); chk("R4 reserved read 0", v, ENM);
        en_clr(32'hFFFF_FFFF);
        rd(8'h04, v, "R3 valid"); chk("R5 clear all", v, 32'h0);
    endtask

    task automatic t_disable;
        logic [31:0] v;
        en_set(32'h8000_0048);
        en_clr(32'h0000_0008);
        rd(8'h04, v, "R3 valid"); chk("R5 partial clear", v, 32'h8000_0040);
        en_clr(32'h8000_0000);
        rd(8'h04, v, "R3 valid"); chk("R5 master clear", v, 32'h0000_0040);
        en_clr(32'h0000_0040);
    endtask

    task automatic t_status;
        logic [31:0] v;
        pulse(32'hFFFF_FFFF); m_st = EVM;
        rd(8'h03, v, "R3 valid"); chk("R6 only event bits latch", v, EVM);
        st_clr(32'h0000_0011);
        rd(8'h03, v, "R3 valid"); chk("R7 w1c", v, 32'h0000_006C);
        // event and clear on bit 2 in the same cycle: set wins
        evt_pulse = 32'h0000_0004;
        cmd(8'h83, 32'h0000_0004);
        evt_pulse = 32'h0;
        rd(8'h03, v, "R3 valid"); chk("R7 set beats clear", v, 32'h0000_006C);
        st_clr(32'hFFFF_FFFF);
        rd(8'h03, v, "R3 valid"); chk("R7 clear all", v, 32'h0);
    endtask

    task automatic t_master;
        en_set(32'h0000_0001);
        pulse(32'h0000_0001); m_st = 32'h1;
        @(negedge clk);
        chk("R8 masked by master", {31'h0, irq_req}, 32'h0);
        en_set(32'h8000_0000);
        chk("R8 not yet", {31'h0, irq_req}, 32'h0);
        @(negedge clk);
        chk("R8 rises", {31'h0, irq_req}, 32'h1);
        en_clr(32'h8000_0000);
        chk("R8 held one cycle", {31'h0, irq_req}, 32'h1);
        @(negedge clk);
        chk("R8 falls", {31'h0, irq_req}, 32'h0);
        st_clr(32'h1); en_clr(32'h1);
    endtask

    task automatic t_each_event;
        int pos [6] = '{0, 2, 3, 4, 5, 6};
        en_set(32'h8000_0000);
        foreach (pos[k]) begin
            logic [31:0] b;
            b = 32'h1 << pos[k];
            en_set(EVM & ~b);
            en_clr(EVM & ~b);
            pulse(b);
            @(negedge clk);
            chk($sformatf("R9 bit %0d disabled", pos[k]), {31'h0, irq_req}, 32'h0);
            en_set(b);
            @(negedge clk);
            chk($sformatf("R9 bit %0d enabled", pos[k]), {31'h0, irq_req}, 32'h1);
            st_clr(b);
            @(negedge clk);
            chk($sformatf("R8 bit %0d cleared", pos[k]), {31'h0, irq_req}, 32'h0);
            en_clr(b);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_set_only;
        t_reserved;
        t_disable;
        t_status;
        t_master;
        t_each_event;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule